// File: doc/BRIEF.md
# Serial Audio Sample Transmitter

This block takes pairs of 16-bit two's complement audio samples (left and right) from an internal converter and sends them MSB first on a single serial data line. The bit clock and the word clock come from outside the block. Both are brought into the master clock domain through two-flop synchronizers, and their edges are detected there. The serial line changes only in response to a detected bit-clock falling edge or word-clock edge, so a receiver can sample it on the rising edge of the bit clock.

Samples arrive over a one-cycle parallel strobe into a pending buffer. A second buffer holds the pair currently on the line, so a newly arriving pair never disturbs what is being shifted out. In standard mode the format is left-justified. The pending pair moves to the line buffer only at the start of a frame, which is the word-clock rising edge. The left word goes out while the word clock is high and the right word while it is low, so both words of a frame come from the same sampling instant. In arbitrary-timing mode, each word-clock edge takes the newest pair. A rising edge latches its left word and a falling edge latches its right word, and the latched word is held on the line for that whole phase.

Top module: `serial_audio_tx`

## Requirements
- R1: Each word is sent MSB first as 16-bit two's complement. The left word is sent while the word clock is high and the right word while it is low.
- R2: Left-justified: the MSB is on the line in the first bit slot of each word-clock phase. A word-clock edge takes priority over a coincident bit-clock falling edge.
- R3: After the 16th bit of a phase, the line is driven 0 for the rest of the phase. This holds for 16, 24 and 32 bit-clock periods per phase (32, 48 and 64 per sample period).
- R4: A pair loaded while a frame is being sent does not change that frame. It is sent starting from the next word-clock rising edge.
- R5: In standard mode (modeArb = 0), the pending pair is transferred only on a word-clock rising edge. A pair loaded during the high phase leaves the right word of that frame unchanged.
- R6: In arbitrary-timing mode (modeArb = 1), a word-clock rising edge latches the left word of the newest available pair.
- R7: In arbitrary-timing mode, a word-clock falling edge latches the right word of the newest available pair.
- R8: serialOut changes only in the cycle after a detected bit-clock falling edge or word-clock edge.
- R9: While rstN is low, serialOut is 0 and both buffers are cleared. Frames sent after reset with no load carry all-zero words.
- R10: If no new pair has been loaded, the previous pair is sent again.
- R11: If two pairs are loaded before a transfer, the later one is sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeArb | input | 1 | 0: standard left-justified, 1: arbitrary timing |
| sampleValid | input | 1 | One-cycle strobe: sampleLeft/sampleRight hold a new pair |
| sampleLeft | input | 16 | Left sample, two's complement |
| sampleRight | input | 16 | Right sample, two's complement |
| bitClk | input | 1 | External bit clock (asynchronous) |
| wordClk | input | 1 | External word clock, high = left (asynchronous) |
| serialOut | output | 1 | Serial data, changes after bit-clock falling edges |

## Verification
The bench builds the block with its default word width of 16 and two synchronizer stages. It drives a bit clock whose half period is six master cycles, which leaves room for the three-register path from the pin to the line. Phase lengths of 16, 24 and 32 bits exercise the exact-fit case and the zero-filled tails. The bench loads pairs between phases, so the hand-over points of both modes can be observed on the serial line alone.

// File: rtl/sat_pkg.sv
package sat_pkg;
  // Strobes from control to datapath, one master cycle wide
  typedef struct packed {
    logic loadLeft;   // word-clock rising edge: start of left phase
    logic loadRight;  // word-clock falling edge: start of right phase
    logic shift;      // bit-clock falling edge inside a phase
    logic takeNew;    // move pending pair into line buffer if present
  } strobe_t;
endpackage

// File: rtl/sat_sync.sv
module sat_sync #(
  parameter int STAGES = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic rise,
  output logic fall,
  output logic level
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= {(STAGES + 1){RESET_VAL}};
    else       pipe <= {pipe[STAGES-1:0], din};
  end

  assign level = pipe[STAGES-1];
  assign rise  = pipe[STAGES-1] & ~pipe[STAGES];
  assign fall  = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/sat_ctrl.sv
module sat_ctrl
  import sat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    modeArb,
  input  logic    bitClk,
  input  logic    wordClk,
  output strobe_t strobe
);
  logic bitRise, bitFall, bitLevel;
  logic wordRise, wordFall, wordLevel;

  sat_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) bitSync_i (
    .clk(clk), .rstN(rstN), .din(bitClk),
    .rise(bitRise), .fall(bitFall), .level(bitLevel)
  );

  sat_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) wordSync_i (
    .clk(clk), .rstN(rstN), .din(wordClk),
    .rise(wordRise), .fall(wordFall), .level(wordLevel)
  );

  logic wordEdge;
  logic unusedLevels;
  assign unusedLevels = bitRise ^ bitLevel ^ wordLevel;
  assign wordEdge = wordRise | wordFall;

  always_comb begin
    strobe.loadLeft  = wordRise;
    strobe.loadRight = wordFall;
    // a word edge starts a phase; a coincident bit edge must not shift the MSB away
    strobe.shift     = bitFall & ~wordEdge;
    // standard mode keeps a pair together by transferring only at frame start
    strobe.takeNew   = wordRise | (modeArb & wordFall);
  end
endmodule

// File: rtl/sat_datapath.sv
module sat_datapath
  import sat_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic             sampleValid,
  input  logic [WIDTH-1:0] sampleLeft,
  input  logic [WIDTH-1:0] sampleRight,
  output logic             serialOut
);
  logic [WIDTH-1:0] pendLeft, pendRight;
  logic             pendFull;
  logic [WIDTH-1:0] lineLeft, lineRight;
  logic [WIDTH-1:0] shiftReg;
  logic             doTransfer;
  logic [WIDTH-1:0] nextLeft, nextRight;

  assign doTransfer = strobe.takeNew & pendFull;
  assign nextLeft   = doTransfer ? pendLeft  : lineLeft;
  assign nextRight  = doTransfer ? pendRight : lineRight;

  // pending buffer: newest pair wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendLeft  <= '0;
      pendRight <= '0;
      pendFull  <= 1'b0;
    end else begin
      if (doTransfer) pendFull <= 1'b0;
      if (sampleValid) begin
        pendLeft  <= sampleLeft;
        pendRight <= sampleRight;
        pendFull  <= 1'b1;
      end
    end
  end

  // line buffer: pair currently being sent
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineLeft  <= '0;
      lineRight <= '0;
    end else if (doTransfer) begin
      lineLeft  <= pendLeft;
      lineRight <= pendRight;
    end
  end

  // output shifter, zero-filled behind the LSB
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 shiftReg <= '0;
    else if (strobe.loadLeft)  shiftReg <= nextLeft;
    else if (strobe.loadRight) shiftReg <= nextRight;
    else if (strobe.shift)     shiftReg <= {shiftReg[WIDTH-2:0], 1'b0};
  end

  assign serialOut = shiftReg[WIDTH-1];
endmodule

// File: rtl/serial_audio_tx.sv
module serial_audio_tx #(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeArb,
  input  logic             sampleValid,
  input  logic [WIDTH-1:0] sampleLeft,
  input  logic [WIDTH-1:0] sampleRight,
  input  logic             bitClk,
  input  logic             wordClk,
  output logic             serialOut
);
  sat_pkg::strobe_t strobe;

  sat_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .modeArb(modeArb),
    .bitClk(bitClk), .wordClk(wordClk), .strobe(strobe)
  );

  sat_datapath #(.WIDTH(WIDTH)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .sampleValid(sampleValid), .sampleLeft(sampleLeft),
    .sampleRight(sampleRight), .serialOut(serialOut)
  );
endmodule

// File: rtl/sat_tx_checker.sv
module sat_tx_checker
  import sat_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input logic    clk,
  input logic    rstN,
  input logic    modeArb,
  input strobe_t strobe,
  input logic    serialOut
);
  localparam int CW = $clog2(WIDTH) + 2;
  localparam logic [CW-1:0] LIMIT = CW'(WIDTH);

  // independent count of shifts since the last phase start
  logic [CW-1:0] shiftCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftCnt <= '0;
    else if (strobe.loadLeft || strobe.loadRight) shiftCnt <= '0;
    else if (strobe.shift && shiftCnt <= LIMIT) shiftCnt <= shiftCnt + 1'b1;
  end

  assert_zero_tail_R3: assert property (@(posedge clk) disable iff (!rstN)
    (shiftCnt >= LIMIT) |-> (serialOut == 1'b0));

  assert_line_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.loadLeft || strobe.loadRight || strobe.shift) |=> $stable(serialOut));

  assert_single_action_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadLeft, strobe.loadRight, strobe.shift}));

  assert_frame_start_only_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.takeNew && !modeArb) |-> strobe.loadLeft);

  assert_arb_right_fresh_R7: assert property (@(posedge clk) disable iff (!rstN)
    (modeArb && strobe.loadRight) |-> strobe.takeNew);

  always @(negedge clk) begin
    if (!rstN) begin
      assert_reset_clear_R9: assert (serialOut == 1'b0);
    end
  end
endmodule

bind serial_audio_tx sat_tx_checker #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rstN(rstN), .modeArb(modeArb),
  .strobe(strobe), .serialOut(serialOut)
);

// File: tb/serial_audio_tx_tb_top.sv
module serial_audio_tx_tb_top;
  localparam int HALF = 6;

  logic        clk = 1'b0;
  logic        rstN;
  logic        modeArb = 1'b0;
  logic        sampleValid = 1'b0;
  logic [15:0] sampleLeft = '0;
  logic [15:0] sampleRight = '0;
  logic        bitClk = 1'b1;
  logic        wordClk = 1'b0;
  logic        serialOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  serial_audio_tx dut_i (
    .clk(clk), .rstN(rstN), .modeArb(modeArb), .sampleValid(sampleValid),
    .sampleLeft(sampleLeft), .sampleRight(sampleRight),
    .bitClk(bitClk), .wordClk(wordClk), .serialOut(serialOut)
  );

  task automatic checkVal(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic loadPair(input logic [15:0] l, input logic [15:0] r);
    @(negedge clk);
    sampleLeft = l; sampleRight = r; sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  // one word-clock phase of nbits bit periods; returns first 16 bits and tail status
  task automatic sendHalf(input logic level, input int nbits,
                          output logic [15:0] word, output logic tailZero);
    word = '0; tailZero = 1'b1;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      bitClk = 1'b0;
      if (i == 0) wordClk = level;
      repeat (HALF) @(negedge clk);
      if (i < 16) word = {word[14:0], serialOut};
      else if (serialOut !== 1'b0) tailZero = 1'b0;
      bitClk = 1'b1;
      repeat (HALF - 1) @(negedge clk);
    end
  endtask

  task automatic sendFrame(input int nbits, output logic [15:0] l, output logic [15:0] r,
                           output logic tz);
    logic tzl, tzr;
    sendHalf(1'b1, nbits, l, tzl);
    sendHalf(1'b0, nbits, r, tzr);
    tz = tzl & tzr;
  endtask

  task automatic testReset();
    logic [15:0] l, r; logic tz;
    @(negedge clk);
    checkVal("R9 reset line", {31'd0, serialOut}, 32'd0);
    sendFrame(16, l, r, tz);
    checkVal("R9 empty left", {16'd0, l}, 32'd0);
    checkVal("R9 empty right", {16'd0, r}, 32'd0);
  endtask

  task automatic testStandard();
    logic [15:0] l, r; logic tz;
    loadPair(16'h8001, 16'h7FFE);
    sendFrame(16, l, r, tz);
    checkVal("R1 left 32fs", {16'd0, l}, 32'h8001);
    checkVal("R2 right 32fs", {16'd0, r}, 32'h7FFE);
    loadPair(16'hA5C3, 16'h1234);
    sendFrame(24, l, r, tz);
    checkVal("R3 left 48fs", {16'd0, l}, 32'hA5C3);
    checkVal("R3 right 48fs", {16'd0, r}, 32'h1234);
    checkVal("R3 tail 48fs", {31'd0, tz}, 32'd1);
    loadPair(16'hFFFF, 16'hC001);
    sendFrame(32, l, r, tz);
    checkVal("R3 left 64fs", {16'd0, l}, 32'hFFFF);
    checkVal("R3 right 64fs", {16'd0, r}, 32'hC001);
    checkVal("R3 tail 64fs", {31'd0, tz}, 32'd1);
    sendFrame(24, l, r, tz);
    checkVal("R10 repeat left", {16'd0, l}, 32'hFFFF);
    checkVal("R10 repeat right", {16'd0, r}, 32'hC001);
  endtask

  task automatic testDoubleBuffer();
    logic [15:0] l, r; logic tz;
    loadPair(16'h1111, 16'h2222);
    sendHalf(1'b1, 16, l, tz);
    loadPair(16'h3333, 16'h4444);
    sendHalf(1'b0, 16, r, tz);
    checkVal("R4 left kept", {16'd0, l}, 32'h1111);
    checkVal("R5 right same instant", {16'd0, r}, 32'h2222);
    sendFrame(16, l, r, tz);
    checkVal("R4 next left", {16'd0, l}, 32'h3333);
    checkVal("R4 next right", {16'd0, r}, 32'h4444);
    loadPair(16'h0F0F, 16'hF0F0);
    loadPair(16'h6789, 16'h9876);
    sendFrame(16, l, r, tz);
    checkVal("R11 newest left", {16'd0, l}, 32'h6789);
    checkVal("R11 newest right", {16'd0, r}, 32'h9876);
  endtask

  task automatic testArbitrary();
    logic [15:0] l, r; logic tz;
    modeArb = 1'b1;
    loadPair(16'hBEEF, 16'hDEAD);
    sendHalf(1'b1, 24, l, tz);
    checkVal("R6 arb left", {16'd0, l}, 32'hBEEF);
    checkVal("R3 arb tail", {31'd0, tz}, 32'd1);
    loadPair(16'h5A5A, 16'hC3C3);
    sendHalf(1'b0, 24, r, tz);
    checkVal("R7 arb right newest", {16'd0, r}, 32'hC3C3);
    sendHalf(1'b1, 24, l, tz);
    checkVal("R6 arb left held pair", {16'd0, l}, 32'h5A5A);
    sendHalf(1'b0, 24, r, tz);
    checkVal("R10 arb right repeat", {16'd0, r}, 32'hC3C3);
    modeArb = 1'b0;
  endtask

  initial begin
    rstN = 1'b0;
    repeat (20) @(negedge clk);
    testResetPre: begin
      checkVal("R9 line in reset", {31'd0, serialOut}, 32'd0);
    end
    rstN = 1'b1;
    testReset();
    testStandard();
    testDoubleBuffer();
    testArbitrary();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule